// File: doc/BRIEF.md
# Cell Sequence Header Protector

This block builds and checks the one-byte header that precedes the 47-byte payload of a constant-bit-rate adaptation cell. On the transmit side each request produces a header byte. The byte holds a convergence indication bit, a modulo-8 sequence count kept by the block, a 3-bit CRC over those four bits, and an even parity bit. On the receive side each header byte offered is decoded. A single flipped bit anywhere in the byte is repaired. Two flipped bits are rejected. The recovered indication bit and count are reported together with status flags, so that surrounding logic can release or drop the payload.

The receiver also tracks continuity. A good cell whose count does not follow the last good count raises a sequence-error flag. The receiver also collects a 4-bit time stamp that travels one bit at a time in the indication bits of the odd-numbered cells. When a good count-7 cell closes a set, the stamp is presented with a one-cycle strobe. Payload bytes pass outside this block; only the header is handled here.

Top module: `seqhdr_protect`

## Requirements
- R1: When `tx_req` is high, `tx_vld` is high on the next cycle and `tx_hdr` holds: bit 7 the indication bit `tx_csi`, bits 6:4 the sequence count, bits 3:1 the remainder of ({bit7..bit4} · x^3) divided by x^3 + x + 1 (bit 7 as the highest-order input), and bit 0 set so that the byte has an even number of ones.
- R2: After reset the first transmitted count is 0, and each following request uses the previous count plus one, modulo 8.
- R3: One cycle after `rx_in_vld`, `rx_done` is high. For an error-free header, `rx_good`=1, `rx_fixed`=0, `rx_bad`=0, and `rx_csi`/`rx_cnt` equal bits 7 and 6:4 of the header.
- R4: A header with exactly one bit flipped, at any of the 8 positions, gives `rx_good`=1 and `rx_fixed`=1, with `rx_csi`/`rx_cnt` equal to the values before the flip.
- R5: A header with exactly two bits flipped gives `rx_bad`=1 and `rx_good`=0. A bad cell changes neither the continuity state nor the time-stamp state.
- R6: `rx_seq_err` is high with a good cell whose count differs from the last good count plus one, modulo 8. The first good cell after reset never raises it.
- R7: `ts_stb` is high with a good count-7 cell when good cells with counts 1, 3 and 5 have arrived since the last good count-7 cell, the count-1 cell coming first. `ts_val` is then {csi of count 1, csi of count 3, csi of count 5, csi of count 7}, MSB first. A good count-1 cell starts a new set.
- R8: While `rx_done` is low, `rx_good`, `rx_fixed`, `rx_bad`, `rx_seq_err` and `ts_stb` are all low. Reset leaves every output at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Build one transmit header |
| tx_csi | input | 1 | Indication bit for the transmit header |
| tx_hdr | output | 8 | Built header byte |
| tx_vld | output | 1 | `tx_hdr` is new this cycle |
| rx_in_vld | input | 1 | A received header is offered |
| rx_hdr | input | 8 | Received header byte |
| rx_done | output | 1 | Decode result is valid this cycle |
| rx_csi | output | 1 | Recovered indication bit |
| rx_cnt | output | 3 | Recovered sequence count |
| rx_good | output | 1 | Header error-free or repaired; payload may be released |
| rx_fixed | output | 1 | A single-bit error was repaired |
| rx_bad | output | 1 | Uncorrectable header; cell rejected |
| rx_seq_err | output | 1 | Count broke continuity |
| ts_stb | output | 1 | Time stamp complete |
| ts_val | output | 4 | Assembled time stamp |

## Verification
A repaired header and a finished time stamp can land on the same cycle: a count-7 cell with one flipped bit must both report the repair and close the stamp with its recovered indication bit. The bench provokes this by flipping each of the eight bit positions in turn across a full count cycle, so that count 7 carries a flip. It expects the strobe and the stamp together with the repair flag. A sequence error can likewise coincide with either event. That case follows a rejected cell, and the bench confirms that the rejected cell left both the continuity state and the stamp state untouched.

// File: rtl/seqhdr_pkg.sv
package seqhdr_pkg;
    localparam int SEQ_W  = 3;
    localparam int SN_W   = SEQ_W + 1;
    localparam int CRC_W  = 3;
    localparam int HDR_W  = SN_W + CRC_W + 1;
    localparam int CW_W   = HDR_W - 1;          // bits covered by the CRC
    localparam int TS_W   = 4;
    localparam int SLOT_W = SEQ_W - 1;
    localparam logic [CRC_W-1:0] GEN_LOW = 3'b011;  // x^3 + x + 1 without x^3

    typedef struct packed {
        logic             csi;
        logic [SEQ_W-1:0] cnt;
    } sn_t;

    typedef struct packed {
        sn_t  sn;
        logic good;
        logic fixed;
        logic bad;
    } dec_t;

    // v(x) mod g(x), highest bit first
    function automatic logic [CRC_W-1:0] poly_rem(input logic [CW_W-1:0] v);
        logic [CRC_W-1:0] r;
        logic             top;
        r = '0;
        for (int i = CW_W - 1; i >= 0; i--) begin
            top = r[CRC_W-1];
            r   = {r[CRC_W-2:0], v[i]};
            if (top) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] sn_crc(input sn_t sn);
        return poly_rem({sn, {CRC_W{1'b0}}});
    endfunction

    // position of a single error among the CRC-covered bits
    function automatic logic [CW_W-1:0] err_loc(input logic [CRC_W-1:0] syn);
        logic [CW_W-1:0] m;
        m = '0;
        for (int k = 0; k < CW_W; k++)
            if (poly_rem(CW_W'(1) << k) == syn) m[k] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/seqhdr_tx_build.sv
module seqhdr_tx_build
    import seqhdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             csi,
    output logic [HDR_W-1:0] hdr,
    output logic             vld
);
    logic [SEQ_W-1:0] cnt_q;
    sn_t              sn;
    logic [CRC_W-1:0] crc;

    always_comb begin
        sn.csi = csi;
        sn.cnt = cnt_q;
        crc    = sn_crc(sn);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            hdr   <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= req;
            if (req) begin
                hdr   <= {sn, crc, ^{sn, crc}};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seqhdr_rx_check.sv
module seqhdr_rx_check
    import seqhdr_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output dec_t             dec
);
    logic [CRC_W-1:0] syn;
    logic             par_odd;
    logic [CW_W-1:0]  flip;
    logic [CW_W-1:0]  cw_fix;

    always_comb begin
        syn     = poly_rem(hdr[HDR_W-1:1]);
        par_odd = ^hdr;
        flip    = (par_odd && syn != '0) ? err_loc(syn) : '0;
        cw_fix  = hdr[HDR_W-1:1] ^ flip;

        dec.sn    = sn_t'(cw_fix[CW_W-1:CRC_W]);
        dec.good  = par_odd || (syn == '0);
        dec.fixed = par_odd;
        dec.bad   = !par_odd && (syn != '0);
    end
endmodule

// File: rtl/seqhdr_ts_gather.sv
module seqhdr_ts_gather
    import seqhdr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            vld,
    input  dec_t            dec,
    output logic            seq_err,
    output logic            ts_stb,
    output logic [TS_W-1:0] ts_val
);
    logic [SEQ_W-1:0]  prev_q;
    logic              have_q;
    logic [TS_W-1:0]   got_q;
    logic [TS_W-1:0]   bit_q;
    logic              take;
    logic [SLOT_W-1:0] slot;

    assign take = vld && dec.good;
    assign slot = dec.sn.cnt[SEQ_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            have_q  <= 1'b0;
            got_q   <= '0;
            bit_q   <= '0;
            seq_err <= 1'b0;
            ts_stb  <= 1'b0;
            ts_val  <= '0;
        end else begin
            seq_err <= take && have_q && (dec.sn.cnt != prev_q + 1'b1);
            ts_stb  <= 1'b0;
            if (take) begin
                prev_q <= dec.sn.cnt;
                have_q <= 1'b1;
            end
            if (take && dec.sn.cnt[0]) begin
                if (slot == '0) begin
                    got_q    <= TS_W'(1);
                    bit_q[0] <= dec.sn.csi;
                end else if (slot == SLOT_W'(TS_W - 1)) begin
                    ts_stb <= &got_q[TS_W-2:0];
                    if (&got_q[TS_W-2:0])
                        ts_val <= {bit_q[0], bit_q[1], bit_q[2], dec.sn.csi};
                    got_q <= '0;
                end else begin
                    got_q[slot] <= 1'b1;
                    bit_q[slot] <= dec.sn.csi;
                end
            end
        end
    end
endmodule

// File: rtl/seqhdr_protect.sv
module seqhdr_protect
    import seqhdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_req,
    input  logic       tx_csi,
    output logic [7:0] tx_hdr,
    output logic       tx_vld,
    input  logic       rx_in_vld,
    input  logic [7:0] rx_hdr,
    output logic       rx_done,
    output logic       rx_csi,
    output logic [2:0] rx_cnt,
    output logic       rx_good,
    output logic       rx_fixed,
    output logic       rx_bad,
    output logic       rx_seq_err,
    output logic       ts_stb,
    output logic [3:0] ts_val
);
    dec_t dec;

    seqhdr_tx_build u_tx (
        .clk (clk),
        .rst (rst),
        .req (tx_req),
        .csi (tx_csi),
        .hdr (tx_hdr),
        .vld (tx_vld)
    );

    seqhdr_rx_check u_chk_rx (
        .hdr (rx_hdr),
        .dec (dec)
    );

    seqhdr_ts_gather u_ts (
        .clk     (clk),
        .rst     (rst),
        .vld     (rx_in_vld),
        .dec     (dec),
        .seq_err (rx_seq_err),
        .ts_stb  (ts_stb),
        .ts_val  (ts_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_done  <= 1'b0;
            rx_csi   <= 1'b0;
            rx_cnt   <= '0;
            rx_good  <= 1'b0;
            rx_fixed <= 1'b0;
            rx_bad   <= 1'b0;
        end else begin
            rx_done  <= rx_in_vld;
            rx_good  <= rx_in_vld && dec.good;
            rx_fixed <= rx_in_vld && dec.fixed;
            rx_bad   <= rx_in_vld && dec.bad;
            if (rx_in_vld) begin
                rx_csi <= dec.sn.csi;
                rx_cnt <= dec.sn.cnt;
            end
        end
    end
endmodule

// File: rtl/seqhdr_checker.sv
module seqhdr_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_req,
    input logic       tx_csi,
    input logic [7:0] tx_hdr,
    input logic       tx_vld,
    input logic       rx_in_vld,
    input logic [7:0] rx_hdr,
    input logic       rx_done,
    input logic       rx_csi,
    input logic [2:0] rx_cnt,
    input logic       rx_good,
    input logic       rx_fixed,
    input logic       rx_bad,
    input logic       rx_seq_err,
    input logic       ts_stb,
    input logic [3:0] ts_val
);
    logic [2:0] last_cnt;
    logic       seen_tx;

    assert_tx_parity_R1: assert property (@(posedge clk) disable iff (rst)
        tx_vld |-> (^tx_hdr) == 1'b0);

    assert_rx_latency_R3: assert property (@(posedge clk) disable iff (rst)
        rx_in_vld |=> rx_done);

    assert_fixed_is_good_R4: assert property (@(posedge clk) disable iff (rst)
        rx_fixed |-> rx_good);

    assert_good_xor_bad_R5: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $countones({rx_good, rx_bad}) == 1);

    assert_seq_on_good_R6: assert property (@(posedge clk) disable iff (rst)
        rx_seq_err |-> rx_good);

    assert_stamp_on_seven_R7: assert property (@(posedge clk) disable iff (rst)
        ts_stb |-> (rx_good && rx_cnt == 3'd7));

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> !(rx_good || rx_fixed || rx_bad || rx_seq_err || ts_stb));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_tx  <= 1'b0;
            last_cnt <= 3'd0;
        end else if (tx_vld) begin
            assert_tx_step_R2: assert (seen_tx ? (tx_hdr[6:4] == last_cnt + 3'd1)
                                               : (tx_hdr[6:4] == 3'd0));
            seen_tx  <= 1'b1;
            last_cnt <= tx_hdr[6:4];
        end
    end
endmodule

bind seqhdr_protect seqhdr_checker u_chk (.*);

// File: tb/sim_seqhdr_protect.sv
module sim_seqhdr_protect;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_req = 1'b0, tx_csi = 1'b0;
    logic [7:0] tx_hdr;
    logic       tx_vld;
    logic       rx_in_vld = 1'b0;
    logic [7:0] rx_hdr = 8'h00;
    logic       rx_done, rx_csi, rx_good, rx_fixed, rx_bad, rx_seq_err, ts_stb;
    logic [2:0] rx_cnt;
    logic [3:0] ts_val;

    int checks = 0, fails = 0;
    bit finished = 0;

    // expectations for the next sample
    bit       e_tx_vld, e_done, e_good, e_fixed, e_bad, e_seq, e_stb, e_csi;
    int       e_cnt, e_tsv;
    int       e_txh;
    int       tx_count = 0;
    int       prev_good = -1;
    int       ts_bits[4];
    bit       ts_have[4];

    always #10 clk = ~clk;

    seqhdr_protect u0 (.*);

    function automatic int make_hdr(input int csi, input int cnt);
        int v, par;
        v = ((csi << 3) | cnt) << 3;
        for (int i = 6; i >= 3; i--)
            if (v & (1 << i)) v = v ^ (11 << (i - 3));
        v = (csi << 7) | (cnt << 4) | ((v & 7) << 1);
        par = 0;
        for (int i = 1; i < 8; i++) par = par ^ ((v >> i) & 1);
        return v | par;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1 tx_vld", tx_vld, e_tx_vld);
        if (e_tx_vld) begin
            chk("R1 tx header", tx_hdr, e_txh);
            chk("R2 tx count", tx_hdr[6:4], (e_txh >> 4) & 7);
        end
        chk("R3 rx_done", rx_done, e_done);
        if (!e_done) begin
            chk("R8 idle flags", {rx_good, rx_fixed, rx_bad, rx_seq_err, ts_stb}, 0);
        end else begin
            chk(e_bad ? "R5 bad" : (e_fixed ? "R4 fixed" : "R3 clean"),
                {rx_good, rx_fixed, rx_bad}, {e_good, e_fixed, e_bad});
            if (e_good) chk(e_fixed ? "R4 recovered sn" : "R3 sn",
                            {rx_csi, rx_cnt}, (int'(e_csi) << 3) | e_cnt);
            chk("R6 seq_err", rx_seq_err, e_seq);
            chk("R7 ts_stb", ts_stb, e_stb);
            if (e_stb) chk("R7 ts_val", ts_val, e_tsv);
        end
    endtask

    task automatic step(input bit tq, input bit tc, input bit rv,
                        input int csi, input int cnt, input int emask);
        int oh, nerr, slot;
        @(negedge clk);
        compare();
        oh = make_hdr(csi, cnt);
        tx_req = tq; tx_csi = tc; rx_in_vld = rv; rx_hdr = 8'(oh ^ emask);
        e_tx_vld = tq;
        if (tq) begin
            e_txh = make_hdr(tc, tx_count);
            tx_count = (tx_count + 1) % 8;
        end
        e_done = rv; e_good = 0; e_fixed = 0; e_bad = 0; e_seq = 0; e_stb = 0;
        if (rv) begin
            nerr = $countones(emask);
            if (nerr >= 2) e_bad = 1;
            else begin
                e_good = 1; e_fixed = (nerr == 1);
                e_csi = csi[0]; e_cnt = cnt;
                e_seq = (prev_good >= 0) && (cnt != (prev_good + 1) % 8);
                prev_good = cnt;
                if (cnt % 2 == 1) begin
                    slot = cnt / 2;
                    if (slot == 0) begin
                        foreach (ts_have[i]) ts_have[i] = 0;
                        ts_have[0] = 1; ts_bits[0] = csi;
                    end else if (slot == 3) begin
                        e_stb = ts_have[0] && ts_have[1] && ts_have[2];
                        e_tsv = (ts_bits[0] << 3) | (ts_bits[1] << 2) | (ts_bits[2] << 1) | csi;
                        foreach (ts_have[i]) ts_have[i] = 0;
                    end else begin
                        ts_have[slot] = 1; ts_bits[slot] = csi;
                    end
                end
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state: all outputs zero
        chk("R8 reset outputs", {tx_hdr, tx_vld, rx_done, rx_csi, rx_cnt, rx_good,
                                 rx_fixed, rx_bad, rx_seq_err, ts_stb, ts_val}, 0);
        idle(); idle();
        // clean round, stamp 1011, tx running alongside (R1 R2 R3 R7)
        for (int c = 0; c < 8; c++) begin
            int cs;
            cs = (c == 1 || c == 5 || c == 7) ? 1 : 0;
            step(1, c[0], 1, cs, c, 0);
        end
        // single flips at each position incl. count 7 (R4 with R7 same cycle)
        for (int c = 0; c < 8; c++) begin
            int cs;
            cs = (c == 3 || c == 7) ? 1 : 0;
            step(c % 2 == 0, 1, 1, cs, c, 1 << c);
        end
        // reversed flip order, stamp 1111
        for (int c = 0; c < 8; c++) step(0, 0, 1, 1, c, 1 << (7 - c));
        idle();
        // double error at count 3: rejected, breaks stamp, next causes seq err (R5 R6 R7)
        step(1, 0, 1, 0, 0, 0);
        step(1, 1, 1, 1, 1, 0);
        step(1, 0, 1, 0, 2, 0);
        step(0, 0, 1, 1, 3, 8'h81);
        step(0, 0, 1, 0, 4, 0);
        step(0, 0, 1, 1, 5, 0);
        step(0, 0, 1, 0, 6, 8'h30);
        step(0, 0, 1, 1, 7, 0);
        // count-1 cell rejected: no stamp at 7 (R7)
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 1, 1, 8'h06);
        step(0, 0, 1, 0, 2, 0);
        step(0, 0, 1, 1, 3, 0);
        step(0, 0, 1, 0, 4, 0);
        step(0, 0, 1, 1, 5, 0);
        step(0, 0, 1, 0, 6, 0);
        step(0, 0, 1, 1, 7, 0);
        // skip and repeat counts (R6)
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 3, 0);
        step(0, 0, 1, 0, 3, 0);
        step(0, 0, 1, 0, 4, 8'h10);
        idle();
        // every two-bit pattern on a clean count sequence (R5)
        for (int a = 0; a < 8; a++)
            for (int b = a + 1; b < 8; b++)
                step(1, b[0], 1, a[0], b, (1 << a) | (1 << b));
        // good cell after all the rejects follows the last good one (R5 R6)
        step(0, 0, 1, 0, 5, 0);
        step(0, 0, 1, 0, 6, 0);
        idle(); idle();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule